// File: doc/BRIEF.md
# Slow-Clock Reset Sequencer

This block runs on the slow clock of a small microcontroller and orders its reset outputs. A power-on reset input starts a fixed startup wait that covers oscillator start and synchronization. After that, the core-domain reset is released only once the core-supply-good input has been seen high for a qualification period. When the core reset releases, the processor reset, the peripheral reset and the external reset pin follow, each after a cycle count of its own.

Three conditions pull the core reset low again without waiting for a clock edge: loss of the core-supply-good input, and a supply-monitor or brownout detection whose enable input is set. An external reset request is sampled on the clock and restarts the same sequence. Each restart runs the whole chain again from the core reset. A two-bit cause output records which source began the most recent reset. The enables and the pin-length field are static inputs.

Top module: `rst_seq`

## Requirements
- R1: After `por_n` rises, `core_rst_n` first reads high after the ninth rising clock edge: seven edges of startup wait, then the qualification stage.
- R2: A low `core_ok` drives `core_rst_n` low immediately, with no clock edge needed. After `core_ok` returns high, `core_rst_n` releases after the fourth rising edge: two synchronizer stages plus a qualification of one full cycle.
- R3: With `sm_en` high, a high `sm_det` drives `core_rst_n` low immediately. With `sm_en` low, `sm_det` has no effect on any output and leaves `rst_cause` unchanged.
- R4: With `bod_en` high, a high `bod_det` drives `core_rst_n` low immediately. With `bod_en` low, `bod_det` has no effect on any output and leaves `rst_cause` unchanged.
- R5: A detection pulse caught by even one rising edge keeps `core_rst_n` low without a gap. The release comes after the fourth rising edge following the last edge that saw the pulse.
- R6: `proc_rst_n` releases 3 rising edges after `core_rst_n`, and `periph_rst_n` releases 2 edges after that. Neither is ever high while `core_rst_n` is low.
- R7: `pin_rst_n` is low whenever `core_rst_n` is low, and releases 2^(`ext_len`+1) rising edges after `core_rst_n` does. Value 2 gives 8 edges, value 0 gives 2 edges and value 7 gives 256 edges.
- R8: A high `ext_req` is synchronized and restarts the sequence. Its release timing is the same as in R5.
- R9: `rst_cause` encoding: 0 = power-on or core-supply loss, 1 = supply monitor, 2 = brownout, 3 = external request. It reads 0 after power-on. It changes only when a source is seen while the core reset is released. Priority is supply loss, then brownout, then supply monitor, then external.
- R10: An event seen during the processor or peripheral countdown restarts the full sequence from the core reset, and all timings start over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| core_ok | input | 1 | Core supply regulated and good |
| sm_det | input | 1 | Supply-monitor detection |
| bod_det | input | 1 | Brownout detection |
| sm_en | input | 1 | Supply-monitor reset enable |
| bod_en | input | 1 | Brownout reset enable |
| ext_req | input | 1 | External reset request |
| ext_len | input | 3 | Pin reset length code |
| core_rst_n | output | 1 | Core-domain reset, active low |
| proc_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| pin_rst_n | output | 1 | External reset pin drive, active low |
| rst_cause | output | 2 | Source of the last reset |

## Verification
The bench builds the block with its default parameters: a 7-cycle startup, a 1-cycle qualification, gaps of 3 and 2 cycles, and a 3-bit length field. The 3-bit field lets every length code, including the 256-cycle extreme, be reached within a short run. With these values, every release offset can be checked exactly against counts the bench computes. That includes the restart of a countdown still in progress, pulses caught by a single edge, and simultaneous sources that settle the cause priority.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int STARTUP_CYC = 7,
  parameter int QUAL_CYC    = 1,
  parameter int PROC_DLY    = 3,
  parameter int PERIPH_DLY  = 2,
  parameter int LEN_W       = 3
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             core_ok,
  input  logic             sm_det,
  input  logic             bod_det,
  input  logic             sm_en,
  input  logic             bod_en,
  input  logic             ext_req,
  input  logic [LEN_W-1:0] ext_len,
  output logic             core_rst_n,
  output logic             proc_rst_n,
  output logic             periph_rst_n,
  output logic             pin_rst_n,
  output logic [1:0]       rst_cause
);

  localparam int MAXA   = (STARTUP_CYC > QUAL_CYC) ? STARTUP_CYC : QUAL_CYC;
  localparam int MAXB   = (PROC_DLY > PERIPH_DLY) ? PROC_DLY : PERIPH_DLY;
  localparam int MAXC   = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int PCNT_W = (1 << LEN_W) + 1;
  localparam int SH_W   = LEN_W + 1;

  typedef enum logic [2:0] {S_BOOT, S_QUAL, S_PROC, S_PERI, S_RUN} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [PCNT_W-1:0] pcnt;
  logic [1:0]        ok_q, sm_q, bod_q, ext_q;
  logic              sm_s, bod_s, ext_s, evt, pend, hit_now, released;
  logic [SH_W-1:0]   sh;
  logic [PCNT_W-1:0] pin_len;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ok_q  <= '0;
      sm_q  <= '0;
      bod_q <= '0;
      ext_q <= '0;
    end else begin
      ok_q  <= {ok_q[0], core_ok};
      sm_q  <= {sm_q[0], sm_det};
      bod_q <= {bod_q[0], bod_det};
      ext_q <= {ext_q[0], ext_req};
    end
  end

  assign sm_s     = sm_en & sm_q[1];
  assign bod_s    = bod_en & bod_q[1];
  assign ext_s    = ext_q[1];
  assign evt      = ~ok_q[1] | sm_s | bod_s | ext_s;
  assign pend     = ~(&ok_q) | (sm_en & (|sm_q)) | (bod_en & (|bod_q)) | (|ext_q);
  assign hit_now  = ~core_ok | (sm_en & sm_det) | (bod_en & bod_det);
  assign released = (st == S_PROC) | (st == S_PERI) | (st == S_RUN);
  assign sh       = SH_W'(ext_len) + SH_W'(1);
  assign pin_len  = PCNT_W'(1) << sh;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st        <= S_BOOT;
      cnt       <= CNT_W'(STARTUP_CYC - 1);
      rst_cause <= 2'd0;
    end else begin
      case (st)
        S_BOOT: begin
          if (cnt == '0) begin
            st  <= S_QUAL;
            cnt <= CNT_W'(QUAL_CYC);
          end else cnt <= cnt - CNT_W'(1);
        end
        S_QUAL: begin
          if (evt) cnt <= CNT_W'(QUAL_CYC);
          else if (cnt == '0) begin
            st  <= S_PROC;
            cnt <= CNT_W'(PROC_DLY - 1);
          end else cnt <= cnt - CNT_W'(1);
        end
        default: begin
          if (evt) begin
            st        <= S_QUAL;
            cnt       <= CNT_W'(QUAL_CYC);
            rst_cause <= ~ok_q[1] ? 2'd0 : bod_s ? 2'd2 : sm_s ? 2'd1 : 2'd3;
          end else if (st != S_RUN) begin
            if (cnt == '0) begin
              if (st == S_PROC) begin
                st  <= S_PERI;
                cnt <= CNT_W'(PERIPH_DLY - 1);
              end else st <= S_RUN;
            end else cnt <= cnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pcnt <= '0;
    else if (!released) pcnt <= pin_len;
    else if (pcnt != '0) pcnt <= pcnt - PCNT_W'(1);
  end

  assign core_rst_n   = released & ~pend & ~hit_now;
  assign proc_rst_n   = core_rst_n & ((st == S_PERI) | (st == S_RUN));
  assign periph_rst_n = core_rst_n & (st == S_RUN);
  assign pin_rst_n    = core_rst_n & (pcnt == '0);

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic       core_ok,
  input logic       sm_det,
  input logic       bod_det,
  input logic       sm_en,
  input logic       bod_en,
  input logic       core_rst_n,
  input logic       proc_rst_n,
  input logic       periph_rst_n,
  input logic       pin_rst_n,
  input logic [1:0] rst_cause
);

  a_r2_supply_assert: assert property (@(posedge clk) disable iff (!por_n)
    !core_ok |-> !core_rst_n);

  a_r3_monitor_assert: assert property (@(posedge clk) disable iff (!por_n)
    (sm_en && sm_det) |-> !core_rst_n);

  a_r4_brownout_assert: assert property (@(posedge clk) disable iff (!por_n)
    (bod_en && bod_det) |-> !core_rst_n);

  a_r5_release_qualified: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> $past(core_ok, 2));

  a_r6_proc_after_core: assert property (@(posedge clk) disable iff (!por_n)
    $rose(proc_rst_n) |-> $past(core_rst_n));

  a_r6_periph_after_proc: assert property (@(posedge clk) disable iff (!por_n)
    $rose(periph_rst_n) |-> $past(proc_rst_n));

  a_r7_pin_after_core: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pin_rst_n) |-> $past(core_rst_n));

  a_r9_cause_hold: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst_n && $past(core_rst_n)) |-> $stable(rst_cause));

endmodule

bind rst_seq rst_seq_chk u_chk (
  .clk(clk), .por_n(por_n), .core_ok(core_ok), .sm_det(sm_det), .bod_det(bod_det),
  .sm_en(sm_en), .bod_en(bod_en), .core_rst_n(core_rst_n), .proc_rst_n(proc_rst_n),
  .periph_rst_n(periph_rst_n), .pin_rst_n(pin_rst_n), .rst_cause(rst_cause)
);

// File: tb/sim_rst_seq.sv
module sim_rst_seq;
  logic       clk = 0;
  logic       por_n = 0;
  logic       core_ok = 1, sm_det = 0, bod_det = 0, sm_en = 1, bod_en = 1, ext_req = 0;
  logic [2:0] ext_len = 3'd2;
  logic       core_rst_n, proc_rst_n, periph_rst_n, pin_rst_n;
  logic [1:0] rst_cause;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  rst_seq u0 (
    .clk(clk), .por_n(por_n), .core_ok(core_ok), .sm_det(sm_det), .bod_det(bod_det),
    .sm_en(sm_en), .bod_en(bod_en), .ext_req(ext_req), .ext_len(ext_len),
    .core_rst_n(core_rst_n), .proc_rst_n(proc_rst_n), .periph_rst_n(periph_rst_n),
    .pin_rst_n(pin_rst_n), .rst_cause(rst_cause)
  );

  function automatic int pin_cycles(input int len);
    return 1 << (len + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic measure(input int exp_core, input int exp_cause, input string tag);
    int kc = -1, kp = -1, kq = -1, kn = -1;
    for (int k = 1; k <= 400; k++) begin
      step();
      if (kc < 0 && core_rst_n) kc = k;
      if (kp < 0 && proc_rst_n) kp = k;
      if (kq < 0 && periph_rst_n) kq = k;
      if (kn < 0 && pin_rst_n) kn = k;
      if (kn > 0 && kq > 0) break;
    end
    chk({tag, " R1/R5 core release"}, kc, exp_core);
    chk({tag, " R6 proc gap"}, kp - kc, 3);
    chk({tag, " R6 periph gap"}, kq - kp, 2);
    chk({tag, " R7 pin length"}, kn - kc, pin_cycles(int'(ext_len)));
    chk({tag, " R9 cause"}, int'(rst_cause), exp_cause);
  endtask

  task automatic set_src(input int src, input logic v);
    case (src)
      0: core_ok = ~v;
      1: sm_det = v;
      2: bod_det = v;
      default: ext_req = v;
    endcase
  endtask

  task automatic fire(input int src, input int hold, input string tag);
    @(negedge clk);
    set_src(src, 1'b1);
    #1;
    if (src == 0) chk({tag, " R2 immediate"}, int'(core_rst_n), 0);
    else if (src == 1) chk({tag, " R3 immediate"}, int'(core_rst_n), 0);
    else if (src == 2) chk({tag, " R4 immediate"}, int'(core_rst_n), 0);
    for (int i = 1; i < hold; i++) @(negedge clk);
    @(negedge clk);
    set_src(src, 1'b0);
    #0;
  endtask

  task automatic ignored(input int src, input string req);
    int bad = 0;
    logic [1:0] c0 = rst_cause;
    @(negedge clk);
    set_src(src, 1'b1);
    for (int i = 0; i < 4; i++) begin step(); if (!core_rst_n || !periph_rst_n || !pin_rst_n) bad++; end
    set_src(src, 1'b0);
    for (int i = 0; i < 4; i++) begin step(); if (!core_rst_n || !periph_rst_n || !pin_rst_n) bad++; end
    chk({req, " disabled source ignored"}, bad, 0);
    chk({req, " cause unchanged"}, int'(rst_cause), int'(c0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    chk("R1 reset core", int'(core_rst_n), 0);
    chk("R6 reset proc", int'(proc_rst_n), 0);
    chk("R6 reset periph", int'(periph_rst_n), 0);
    chk("R7 reset pin", int'(pin_rst_n), 0);
    chk("R9 reset cause", int'(rst_cause), 0);
    @(negedge clk);
    por_n = 1;
    measure(9, 0, "power-on");

    fire(1, 3, "sm");
    measure(4, 1, "sm");
    fire(2, 1, "bod short");
    measure(4, 2, "bod short R5");
    fire(0, 2, "supply");
    measure(4, 0, "supply");
    ext_len = 3'd0;
    fire(3, 2, "ext R8");
    measure(4, 3, "ext R8");
    ext_len = 3'd7;
    fire(1, 2, "sm long pin");
    measure(4, 1, "sm long pin");

    sm_en = 0;
    ignored(1, "R3");
    sm_en = 1;
    bod_en = 0;
    ignored(2, "R4");
    bod_en = 1;

    ext_len = 3'd2;
    @(negedge clk);
    sm_det = 1; bod_det = 1;
    repeat (2) @(negedge clk);
    sm_det = 0; bod_det = 0;
    measure(4, 2, "priority bod over sm R9");
    @(negedge clk);
    sm_det = 1; core_ok = 0;
    repeat (2) @(negedge clk);
    sm_det = 0; core_ok = 1;
    measure(4, 0, "priority supply R9");

    fire(1, 2, "hold cause");
    fire(3, 2, "hold cause");
    measure(4, 1, "cause kept during reset R9");

    fire(3, 1, "restart");
    while (!core_rst_n) step();
    step();
    fire(2, 1, "restart R10");
    measure(4, 2, "restart R10");

    for (int it = 0; it < 25; it++) begin
      int src = int'($urandom % 4);
      int hold = 1 + int'($urandom % 5);
      ext_len = 3'($urandom % 8);
      if ((src == 1 || src == 2) && ($urandom % 4) == 0) begin
        if (src == 1) begin sm_en = 0; ignored(1, "rand R3"); sm_en = 1; end
        else begin bod_en = 0; ignored(2, "rand R4"); bod_en = 1; end
      end else begin
        fire(src, hold, "rand");
        measure(4, src, "rand");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule